// File: doc/BRIEF.md
# Privilege Exception and Interrupt Vectoring Unit

This control block sits beside the datapath of a small 16-bit processor and owns the privilege bit of the status word. It screens every memory access the datapath wants to start. A user-mode access that reaches into the protected low region is stopped in the same cycle, before any memory cycle begins, and is turned into a protection exception. Reads of the trap table made by a TRAP instruction are exempt from this check. The block also counts clock cycles from reset and raises a single timer interrupt at a fixed count.

When an event is taken, the block drives the handler entry sequence. It drops to supervisor mode and hands the datapath the supervisor stack pointer while keeping the user one. It then pushes the saved status word and the return PC on the supervisor stack. Last, it presents the address of the handler-table entry, which is the table base plus twice the vector index, because each entry is one 16-bit word. A return-from-interrupt issued in supervisor mode restores the privilege bit and swaps the stack pointers back.

Pushes leave on a valid/ready stream. An item stays on `push_addr`/`push_data` with `push_valid` high until a cycle in which `push_ready` is also high. The sequencer waits for as many cycles as the memory side holds `push_ready` low. All other pins are plain single-cycle control and status.

Top module: `priv_exc_unit`

## Requirements
- R1: After reset, `user_mode` is 1, `irq_pending` is 0, and `push_valid`, `vec_valid` and `sp_load` are 0.
- R2: In user mode, an access with `acc_valid`=1 to an address below 0x3000 that is not exempt drives `prot_fault`=1 and `mem_start`=0 in that same cycle. An access at 0x3000 or above gives `mem_start`=1 and `prot_fault`=0.
- R3: In user mode, an access with `acc_trap`=1 to an address in 0x0000..0x01FF raises no fault and starts memory. A TRAP access at 0x0200 still faults.
- R4: In supervisor mode (`user_mode`=0), no access faults, and the block recognises neither exceptions nor interrupts.
- R5: `irq_pending` rises after exactly the 300th rising clock edge following reset release, and never again. A pending interrupt is taken only in a cycle with `insn_boundary`=1 in user mode, and taking it clears `irq_pending`.
- R6: In the cycle after an event is taken, `user_mode` is 0, `sp_load`=1 and `sp_value` is the saved supervisor stack pointer (0x3000 after reset). Two pushes then follow: first {1, `cur_status`} at SSP-2, then `cur_pc` at SSP-4, both values as captured when the event was taken. Then comes a one-cycle `vec_valid` with `sp_load`=1 and `sp_value`=SSP-4.
- R7: `vec_addr` equals 0x0200 + (vector << 1). The protection exception uses vector 0x02 (0x0204) and the timer interrupt uses vector 0x01 (0x0202).
- R8: When a fault and a boundary with a pending interrupt fall in the same cycle, the exception is taken and the interrupt stays pending until a later boundary in user mode.
- R9: With `rti_valid`=1 in supervisor mode, `user_mode` takes `rti_priv` at the next edge. If `rti_priv`=1, `sp_load`=1 in that cycle with `sp_value` set to the saved user stack pointer, and `cur_sp` becomes the new saved supervisor pointer. `rti_valid` in user mode has no effect.
- R10: While `push_valid`=1 and `push_ready`=0, the push item is held unchanged into the next cycle.
- R11: No memory access starts and no fault is raised while the entry sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Datapath wants to start a memory access |
| acc_addr | input | 16 | Address of the requested access |
| acc_trap | input | 1 | Access is a TRAP table read |
| mem_start | output | 1 | Access may start this cycle |
| prot_fault | output | 1 | Access blocked, protection exception taken |
| insn_boundary | input | 1 | Datapath is between instructions |
| irq_pending | output | 1 | Timer interrupt is waiting |
| cur_pc | input | 16 | PC to save on entry |
| cur_status | input | 15 | Low status bits to save on entry |
| cur_sp | input | 16 | Current stack pointer register |
| rti_valid | input | 1 | Return-from-interrupt pops are done |
| rti_priv | input | 1 | Privilege bit from the popped status word |
| user_mode | output | 1 | Status bit 15: 1 user, 0 supervisor |
| sp_load | output | 1 | Datapath loads `sp_value` into its stack pointer |
| sp_value | output | 16 | New stack pointer value |
| push_valid | output | 1 | Push item valid |
| push_ready | input | 1 | Memory accepts the push item |
| push_addr | output | 16 | Push address |
| push_data | output | 16 | Push data |
| vec_valid | output | 1 | Handler-table address valid (one cycle) |
| vec_addr | output | 16 | Handler-table entry address |

## Verification
The bound assertions check several properties on every cycle. A fault never coincides with a memory start, and supervisor mode never raises a fault. A stalled push holds its item. A drop to supervisor mode always comes with a stack-pointer load. Every vector address is one of the two legal table entries, and the timer interrupt rises at most once. Other behaviour only the bench scenarios can show. These include the address boundaries of the protected region and the trap exemption, the exact edge at which the timer fires, and the order and contents of the pushes. They also include the priority of a fault over a pending interrupt, refusal in supervisor mode, and the stack swaps on entry and on return.

// File: rtl/pxv_pkg.sv
package pxv_pkg;
  localparam int WORD_W = 16;
  localparam int VEC_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTER,
    ST_PUSH_SR,
    ST_PUSH_PC,
    ST_VECTOR
  } seq_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] pc;
    logic [WORD_W-2:0] sr;
    logic [VEC_W-1:0]  vec;
  } entry_snap_t;
endpackage

// File: rtl/pxv_prot_check.sv
module pxv_prot_check
  import pxv_pkg::*;
#(
  parameter logic [WORD_W-1:0] LIMIT    = 16'h3000,
  parameter logic [WORD_W-1:0] TRAP_TOP = 16'h01FF
) (
  input  logic              acc_valid,
  input  logic [WORD_W-1:0] acc_addr,
  input  logic              acc_trap,
  input  logic              user_mode,
  input  logic              seq_idle,
  output logic              fault,
  output logic              start
);
  logic below_limit;
  logic exempt;

  always_comb begin
    below_limit = (acc_addr < LIMIT);
    exempt      = acc_trap && (acc_addr <= TRAP_TOP);
    fault       = acc_valid && seq_idle && user_mode && below_limit && !exempt;
    start       = acc_valid && seq_idle && !fault;
  end
endmodule

// File: rtl/pxv_oneshot_timer.sv
module pxv_oneshot_timer
  import pxv_pkg::*;
#(
  parameter int                FIRE_AT = 300,
  parameter logic [VEC_W-1:0]  VEC     = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  output logic             pending,
  output logic [VEC_W-1:0] vec
);
  localparam int CNT_W = $clog2(FIRE_AT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FIRE_AT - 1);

  logic [CNT_W-1:0] cnt;
  logic             fired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      fired   <= 1'b0;
      pending <= 1'b0;
      vec     <= '0;
    end else begin
      if (!fired) begin
        if (cnt == LAST) begin
          fired   <= 1'b1;
          pending <= 1'b1;
          vec     <= VEC;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (take) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/pxv_entry_seq.sv
module pxv_entry_seq
  import pxv_pkg::*;
#(
  parameter logic [WORD_W-1:0] VEC_BASE = 16'h0200,
  parameter logic [WORD_W-1:0] SSP_INIT = 16'h3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_exc,
  input  logic              take_irq,
  input  logic [VEC_W-1:0]  exc_vec,
  input  logic [VEC_W-1:0]  irq_vec,
  input  logic [WORD_W-1:0] cur_pc,
  input  logic [WORD_W-2:0] cur_status,
  input  logic [WORD_W-1:0] cur_sp,
  input  logic              rti_valid,
  input  logic              rti_priv,
  input  logic              push_ready,
  output logic              user_mode,
  output logic              seq_idle,
  output logic              sp_load,
  output logic [WORD_W-1:0] sp_value,
  output logic              push_valid,
  output logic [WORD_W-1:0] push_addr,
  output logic [WORD_W-1:0] push_data,
  output logic              vec_valid,
  output logic [WORD_W-1:0] vec_addr
);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(2);

  seq_state_e        state;
  entry_snap_t       snap;
  logic [WORD_W-1:0] usp_save;
  logic [WORD_W-1:0] ssp_save;
  logic              take;
  logic              rti_ok;

  assign take   = take_exc || take_irq;
  assign rti_ok = (state == ST_IDLE) && rti_valid && !user_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      snap      <= '0;
      usp_save  <= '0;
      ssp_save  <= SSP_INIT;
      user_mode <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (take) begin
            snap.pc   <= cur_pc;
            snap.sr   <= cur_status;
            snap.vec  <= take_exc ? exc_vec : irq_vec;
            usp_save  <= cur_sp;
            user_mode <= 1'b0;
            state     <= ST_ENTER;
          end else if (rti_ok) begin
            user_mode <= rti_priv;
            if (rti_priv) ssp_save <= cur_sp;
          end
        end
        ST_ENTER:   state <= ST_PUSH_SR;
        ST_PUSH_SR: if (push_ready) state <= ST_PUSH_PC;
        ST_PUSH_PC: if (push_ready) state <= ST_VECTOR;
        ST_VECTOR:  state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    seq_idle   = (state == ST_IDLE);
    push_valid = (state == ST_PUSH_SR) || (state == ST_PUSH_PC);
    push_addr  = (state == ST_PUSH_SR) ? ssp_save - STEP : ssp_save - (STEP << 1);
    push_data  = (state == ST_PUSH_SR) ? {1'b1, snap.sr} : snap.pc;
    vec_valid  = (state == ST_VECTOR);
    vec_addr   = VEC_BASE + (WORD_W'(snap.vec) << 1);
    sp_load    = (state == ST_ENTER) || (state == ST_VECTOR) || (rti_ok && rti_priv);
    unique case (state)
      ST_ENTER:  sp_value = ssp_save;
      ST_VECTOR: sp_value = ssp_save - (STEP << 1);
      default:   sp_value = usp_save;
    endcase
  end
endmodule

// File: rtl/priv_exc_unit.sv
module priv_exc_unit
  import pxv_pkg::*;
#(
  parameter logic [WORD_W-1:0] PROT_LIMIT  = 16'h3000,
  parameter logic [WORD_W-1:0] TRAP_TOP    = 16'h01FF,
  parameter int                TIMER_CYCLE = 300,
  parameter logic [VEC_W-1:0]  TIMER_VEC   = 8'h01,
  parameter logic [VEC_W-1:0]  PROT_VEC    = 8'h02,
  parameter logic [WORD_W-1:0] VEC_BASE    = 16'h0200,
  parameter logic [WORD_W-1:0] SSP_INIT    = 16'h3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [WORD_W-1:0] acc_addr,
  input  logic              acc_trap,
  output logic              mem_start,
  output logic              prot_fault,
  input  logic              insn_boundary,
  output logic              irq_pending,
  input  logic [WORD_W-1:0] cur_pc,
  input  logic [WORD_W-2:0] cur_status,
  input  logic [WORD_W-1:0] cur_sp,
  input  logic              rti_valid,
  input  logic              rti_priv,
  output logic              user_mode,
  output logic              sp_load,
  output logic [WORD_W-1:0] sp_value,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [WORD_W-1:0] push_addr,
  output logic [WORD_W-1:0] push_data,
  output logic              vec_valid,
  output logic [WORD_W-1:0] vec_addr
);
  logic             seq_idle;
  logic             take_irq;
  logic [VEC_W-1:0] irq_vec;

  pxv_prot_check #(.LIMIT(PROT_LIMIT), .TRAP_TOP(TRAP_TOP)) u_check (
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_trap(acc_trap),
    .user_mode(user_mode), .seq_idle(seq_idle),
    .fault(prot_fault), .start(mem_start)
  );

  // a fault wins over a boundary interrupt in the same cycle
  assign take_irq = irq_pending && insn_boundary && user_mode && seq_idle && !prot_fault;

  pxv_oneshot_timer #(.FIRE_AT(TIMER_CYCLE), .VEC(TIMER_VEC)) u_timer (
    .clk(clk), .rst_n(rst_n), .take(take_irq),
    .pending(irq_pending), .vec(irq_vec)
  );

  pxv_entry_seq #(.VEC_BASE(VEC_BASE), .SSP_INIT(SSP_INIT)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .take_exc(prot_fault), .take_irq(take_irq),
    .exc_vec(PROT_VEC), .irq_vec(irq_vec),
    .cur_pc(cur_pc), .cur_status(cur_status), .cur_sp(cur_sp),
    .rti_valid(rti_valid), .rti_priv(rti_priv), .push_ready(push_ready),
    .user_mode(user_mode), .seq_idle(seq_idle),
    .sp_load(sp_load), .sp_value(sp_value),
    .push_valid(push_valid), .push_addr(push_addr), .push_data(push_data),
    .vec_valid(vec_valid), .vec_addr(vec_addr)
  );
endmodule

// File: rtl/pxv_checker.sv
module pxv_checker #(
  parameter logic [15:0] VEC_BASE  = 16'h0200,
  parameter logic [7:0]  TIMER_VEC = 8'h01,
  parameter logic [7:0]  PROT_VEC  = 8'h02
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_start,
  input logic        prot_fault,
  input logic        irq_pending,
  input logic        user_mode,
  input logic        sp_load,
  input logic        push_valid,
  input logic        push_ready,
  input logic [15:0] push_addr,
  input logic [15:0] push_data,
  input logic        vec_valid,
  input logic [15:0] vec_addr
);
  logic irq_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_seen <= 1'b0;
    else        irq_seen <= irq_seen || irq_pending;
  end

  assert_fault_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prot_fault |-> !mem_start);

  assert_sup_no_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !user_mode |-> !prot_fault);

  assert_irq_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pending) |-> !irq_seen);

  assert_enter_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(user_mode) |-> sp_load);

  assert_vec_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_addr == VEC_BASE + {7'd0, PROT_VEC, 1'b0}) ||
                  (vec_addr == VEC_BASE + {7'd0, TIMER_VEC, 1'b0}));

  assert_push_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_addr) && $stable(push_data)));

  assert_seq_no_mem_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid || vec_valid) |-> (!mem_start && !prot_fault));
endmodule

bind priv_exc_unit pxv_checker #(
  .VEC_BASE(VEC_BASE), .TIMER_VEC(TIMER_VEC), .PROT_VEC(PROT_VEC)
) u_pxv_checker (.*);

// File: tb/test_priv_exc_unit.sv
module test_priv_exc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        acc_trap = 1'b0;
  logic        mem_start, prot_fault;
  logic        insn_boundary = 1'b0;
  logic        irq_pending;
  logic [15:0] cur_pc = 16'h3100;
  logic [14:0] cur_status = 15'h0002;
  logic [15:0] cur_sp = 16'hFE00;
  logic        rti_valid = 1'b0;
  logic        rti_priv = 1'b0;
  logic        user_mode, sp_load;
  logic [15:0] sp_value;
  logic        push_valid;
  logic        push_ready = 1'b1;
  logic [15:0] push_addr, push_data;
  logic        vec_valid;
  logic [15:0] vec_addr;

  int n_chk = 0;
  int n_fail = 0;
  int edges = 0;
  logic [31:0] exp_q[$];

  always #5 clk = ~clk;

  priv_exc_unit i_priv_exc_unit (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_trap(acc_trap), .mem_start(mem_start), .prot_fault(prot_fault),
    .insn_boundary(insn_boundary), .irq_pending(irq_pending), .cur_pc(cur_pc),
    .cur_status(cur_status), .cur_sp(cur_sp), .rti_valid(rti_valid),
    .rti_priv(rti_priv), .user_mode(user_mode), .sp_load(sp_load),
    .sp_value(sp_value), .push_valid(push_valid), .push_ready(push_ready),
    .push_addr(push_addr), .push_data(push_data), .vec_valid(vec_valid),
    .vec_addr(vec_addr)
  );

  always @(posedge clk) if (rst_n) edges <= edges + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected pushes, checks hold under back-pressure
  initial begin
    logic        pv = 1'b0;
    logic        pr = 1'b0;
    logic [31:0] pitem = '0;
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        if (pv && !pr) chk("R10 hold", {15'd0, push_valid, push_addr, push_data},
                           {15'd0, 1'b1, pitem});
        if (push_valid && push_ready) begin
          if (exp_q.size() == 0) chk("R6 unexpected push", {push_addr, push_data}, 32'hFFFF_FFFF);
          else chk("R6 push", {push_addr, push_data}, exp_q.pop_front());
        end
        pv = push_valid; pr = push_ready; pitem = {push_addr, push_data};
      end
    end
  end

  // driver side of the scoreboard plus entry handshake
  task automatic service(input string req, input logic [15:0] ssp, input logic [15:0] vaddr,
                         input logic [15:0] pc, input logic [14:0] sr);
    exp_q.push_back({ssp - 16'd2, 1'b1, sr});
    exp_q.push_back({ssp - 16'd4, pc});
    @(negedge clk);
    acc_valid = 1'b0; acc_trap = 1'b0; insn_boundary = 1'b0;
    #1;
    chk({req, " R6 enter sp_load"}, {31'd0, sp_load}, 32'd1);
    chk({req, " R6 enter ssp"}, {16'd0, sp_value}, {16'd0, ssp});
    chk({req, " R6 supervisor"}, {31'd0, user_mode}, 32'd0);
    @(negedge clk);
    push_ready = 1'b0; acc_valid = 1'b1; acc_addr = 16'h4000;
    #1;
    chk({req, " R11 no mem"}, {30'd0, mem_start, prot_fault}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    push_ready = 1'b1; acc_valid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1;
      if (vec_valid) break;
    end
    chk({req, " R7 vec_addr"}, {16'd0, vec_addr}, {16'd0, vaddr});
    chk({req, " R6 final sp"}, {15'd0, sp_load, sp_value}, {15'd0, 1'b1, ssp - 16'd4});
    chk({req, " R6 pushes done"}, exp_q.size(), 32'd0);
  endtask

  task automatic do_rti(input logic [15:0] ssp_now, input logic [15:0] usp_exp);
    @(negedge clk);
    rti_valid = 1'b1; rti_priv = 1'b1; cur_sp = ssp_now;
    #1;
    chk("R9 rti sp swap", {15'd0, sp_load, sp_value}, {15'd0, 1'b1, usp_exp});
    @(negedge clk);
    rti_valid = 1'b0; cur_sp = usp_exp;
    #1;
    chk("R9 back to user", {31'd0, user_mode}, 32'd1);
  endtask

  task automatic access(input logic [15:0] a, input logic trap);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_trap = trap;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset", {26'd0, user_mode, irq_pending, push_valid, vec_valid, sp_load, prot_fault},
        {26'd0, 6'b100000});

    access(16'h3000, 1'b0);
    chk("R2 0x3000 allowed", {30'd0, mem_start, prot_fault}, 32'b10);
    access(16'h2FFF, 1'b0);
    chk("R2 0x2FFF blocked", {30'd0, mem_start, prot_fault}, 32'b01);
    service("R2", 16'h3000, 16'h0204, 16'h3100, 15'h0002);

    access(16'h0100, 1'b0);
    chk("R4 supervisor low access", {30'd0, mem_start, prot_fault}, 32'b10);
    @(negedge clk); acc_valid = 1'b0;
    do_rti(16'h3000, 16'hFE00);

    @(negedge clk);
    rti_valid = 1'b1; rti_priv = 1'b0; cur_sp = 16'h1234;
    #1;
    chk("R9 user rti no sp_load", {31'd0, sp_load}, 32'd0);
    @(negedge clk);
    rti_valid = 1'b0; cur_sp = 16'hFE00;
    #1;
    chk("R9 user rti keeps user", {31'd0, user_mode}, 32'd1);

    access(16'h0000, 1'b1);
    chk("R3 trap 0x0000", {30'd0, mem_start, prot_fault}, 32'b10);
    access(16'h01FF, 1'b1);
    chk("R3 trap 0x01FF", {30'd0, mem_start, prot_fault}, 32'b10);
    cur_pc = 16'h3200; cur_status = 15'h0004;
    access(16'h0200, 1'b1);
    chk("R3 trap 0x0200 faults", {30'd0, mem_start, prot_fault}, 32'b01);
    service("R3", 16'h3000, 16'h0204, 16'h3200, 15'h0004);
    do_rti(16'h3000, 16'hFE00);

    while (edges < 299) @(negedge clk);
    #1;
    chk("R5 not yet at 299", {31'd0, irq_pending}, 32'd0);
    @(negedge clk); #1;
    chk("R5 pending at 300", {31'd0, irq_pending}, 32'd1);
    @(negedge clk); #1;
    chk("R5 no boundary no take", {30'd0, sp_load, user_mode}, 32'b01);

    cur_pc = 16'h3300; cur_status = 15'h0001;
    @(negedge clk);
    insn_boundary = 1'b1; acc_valid = 1'b1; acc_addr = 16'h1000; acc_trap = 1'b0;
    #1;
    chk("R8 fault wins", {31'd0, prot_fault}, 32'd1);
    service("R8", 16'h3000, 16'h0204, 16'h3300, 15'h0001);
    chk("R8 irq still pending", {31'd0, irq_pending}, 32'd1);

    @(negedge clk);
    insn_boundary = 1'b1;
    #1;
    chk("R4 no irq in supervisor", {31'd0, sp_load}, 32'd0);
    @(negedge clk);
    insn_boundary = 1'b0;
    #1;
    chk("R4 still supervisor", {30'd0, push_valid, user_mode}, 32'd0);
    do_rti(16'h3000, 16'hFE00);

    cur_pc = 16'h3400; cur_status = 15'h0007;
    @(negedge clk);
    insn_boundary = 1'b1;
    service("R5", 16'h3000, 16'h0202, 16'h3400, 15'h0007);
    chk("R5 pending cleared", {31'd0, irq_pending}, 32'd0);
    do_rti(16'h3000, 16'hFE00);
    repeat (20) @(negedge clk);
    #1;
    chk("R5 fires once", {31'd0, irq_pending}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule